// File: doc/BRIEF.md
# Memory-Card SPI Initialization Sequencer

This block takes a freshly powered memory card (SD or MMC) into SPI operation and works out which kind of card it is. After a `start` pulse it waits out a settling interval, has the command engine send a burst of idle clocks with chip select released, and then walks a branching command sequence. The sequence is: a software reset, a voltage/version probe, and repeated initialization polls. High-capacity cards get an operating-condition read. Any card that is not block-addressed gets a block-length set.

The sequencer does not shift bits itself. For each step it raises `cmd_req` for one cycle, with the command index, argument, check byte and an "expect 32-bit trailer" flag. The command engine answers with a one-cycle `cmd_ack`, carrying the first reply byte, the optional 32-bit trailer, or a no-response flag. The sequencer drives chip select and the clock-rate select. A single internal timer serves two purposes: the power-up wait and the time limit on initialization polling.

When the sequence succeeds, `ready` rises, the fast clock rate is selected and `card_type` holds the result. Any unexpected reply, a failed check pattern or an expired polling limit raises `error` instead. Both end states hold until reset.

Top module: `sdcard_init_seq`

## Requirements
- R1: While reset is asserted and right after it, `cs_n`=1, `fast_clk`=0, `ready`=0, `error`=0 and `cmd_req`=0.
- R2: After `start`, no request is issued for at least `POWER_WAIT` cycles. The first request is an idle-clock burst (`idle_burst`=1) with `cs_n`=1.
- R3: The reset command has index 0, argument 0 and check byte 0x95, and is sent with `cs_n`=0. A reply other than 0x01, or no reply, leads to `error`.
- R4: The probe command has index 8, argument 0x1AA, check byte 0x87 and `cmd_r32`=1. A reply with bit 2 (illegal command) set selects the legacy path. A reply of 0x01 whose trailer bits [11:0] differ from 0x1AA leads to `error`.
- R5: SD initialization is index 55 followed by index 41. Index 41 has argument bit 30 set exactly when the probe was accepted. The pair is repeated while the reply is 0x01 and stops at reply 0x00.
- R6: On the legacy path, a reply with bit 2 set to index 55 or 41 switches to polling index 1 (argument 0) until reply 0x00. The card is then classified as MMC, `card_type`=0.
- R7: A legacy card that accepts index 41 gets `card_type`=1. A probed card is sent index 58 with `cmd_r32`=1. Trailer bit 30 set gives `card_type`=3 (block addressed); clear gives `card_type`=2.
- R8: For `card_type` 0, 1 and 2, exactly one index-16 command with argument 512 is sent before `ready`. For type 3 none is sent.
- R9: If an initialization poll still answers 0x01 after `INIT_TIMEOUT` cycles have elapsed since the probe reply, the sequencer raises `error` without retrying.
- R10: `ready` and `error` are never both high and hold until reset. With either one high, `cs_n`=1 and no request is made, and a further `start` has no effect. `fast_clk` is 1 only with `ready`.
- R11: `cmd_req` is a single-cycle pulse. No new request is made until the previous one has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Power-stable pulse that begins the sequence |
| cmd_ack | input | 1 | Command engine finished the current request |
| cmd_nores | input | 1 | With `cmd_ack`: the card gave no reply |
| cmd_r1 | input | 8 | With `cmd_ack`: first reply byte |
| cmd_ext | input | 32 | With `cmd_ack`: 32-bit reply trailer |
| cs_n | output | 1 | Card chip select, active low |
| fast_clk | output | 1 | 1 selects the fast SPI clock rate, 0 the slow rate |
| cmd_req | output | 1 | One-cycle request to the command engine |
| idle_burst | output | 1 | Request is an idle-clock burst with data-in high |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_crc | output | 8 | Command check byte |
| cmd_r32 | output | 1 | Reply carries a 32-bit trailer |
| card_type | output | 2 | 0 MMC, 1 SD v1, 2 SD v2 byte-addressed, 3 SD v2 block-addressed |
| ready | output | 1 | Initialization completed |
| error | output | 1 | Initialization failed |

## Verification
A behavioural card model in the bench is configured for each of the four card kinds. Each kind has a different number of busy polls and random reply latency. This separates the MMC fallback, the SD v1 path without the capacity bit, and the two SD v2 outcomes of the capacity read, and it confirms the poll counts and the block-length command. Directed cases are also run:
- a wrong probe echo, to tell the rejection check from a plain SD v2 success;
- a bad reset reply and a missing reset reply;
- a card that never leaves the idle state, to exercise the polling limit.

A second `start` after completion checks that the end state is terminal.

// File: rtl/sdcard_init_seq.sv
module sdcard_init_seq #(
  parameter int POWER_WAIT   = 50000,
  parameter int INIT_TIMEOUT = 50000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        cmd_ack,
  input  logic        cmd_nores,
  input  logic [7:0]  cmd_r1,
  input  logic [31:0] cmd_ext,
  output logic        cs_n,
  output logic        fast_clk,
  output logic        cmd_req,
  output logic        idle_burst,
  output logic [5:0]  cmd_idx,
  output logic [31:0] cmd_arg,
  output logic [7:0]  cmd_crc,
  output logic        cmd_r32,
  output logic [1:0]  card_type,
  output logic        ready,
  output logic        error
);
  localparam int MAXC = (INIT_TIMEOUT > POWER_WAIT) ? INIT_TIMEOUT : POWER_WAIT;
  localparam int TW   = $clog2(MAXC + 2);

  typedef enum logic [3:0] {
    S_IDLE, S_PWAIT, S_BURST, S_RST, S_PROBE, S_APP, S_SDOP,
    S_MMCOP, S_OCR, S_BLEN, S_DONE, S_FAIL
  } st_t;

  st_t           st;
  logic          pend, v2, tmo, in_cmd, r1_idle, r1_ok, r1_illeg;
  logic [1:0]    typ;
  logic [TW-1:0] tmr;

  assign in_cmd   = (st == S_BURST) || (st == S_RST) || (st == S_PROBE) || (st == S_APP) ||
                    (st == S_SDOP) || (st == S_MMCOP) || (st == S_OCR) || (st == S_BLEN);
  assign cmd_req    = in_cmd & ~pend;
  assign idle_burst = (st == S_BURST);
  assign cs_n       = ~(in_cmd & (st != S_BURST));
  assign ready      = (st == S_DONE);
  assign fast_clk   = (st == S_DONE);
  assign error      = (st == S_FAIL);
  assign card_type  = typ;
  assign tmo        = tmr >= TW'(INIT_TIMEOUT);
  assign r1_idle    = ~cmd_nores & (cmd_r1 == 8'h01);
  assign r1_ok      = ~cmd_nores & (cmd_r1 == 8'h00);
  assign r1_illeg   = ~cmd_nores & cmd_r1[2];

  always_comb begin
    cmd_idx = 6'd0;
    cmd_arg = 32'd0;
    cmd_crc = 8'hFF;
    cmd_r32 = 1'b0;
    case (st)
      S_RST:   cmd_crc = 8'h95;
      S_PROBE: begin cmd_idx = 6'd8; cmd_arg = 32'h0000_01AA; cmd_crc = 8'h87; cmd_r32 = 1'b1; end
      S_APP:   cmd_idx = 6'd55;
      S_SDOP:  begin cmd_idx = 6'd41; cmd_arg = {1'b0, v2, 30'd0}; end
      S_MMCOP: cmd_idx = 6'd1;
      S_OCR:   begin cmd_idx = 6'd58; cmd_r32 = 1'b1; end
      S_BLEN:  begin cmd_idx = 6'd16; cmd_arg = 32'd512; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pend <= 1'b0;
      v2   <= 1'b0;
      typ  <= 2'd0;
      tmr  <= '0;
    end else begin
      if (!(&tmr)) tmr <= tmr + 1'b1;
      if (cmd_req) pend <= 1'b1;
      if (cmd_ack) pend <= 1'b0;
      case (st)
        S_IDLE: if (start) begin st <= S_PWAIT; tmr <= '0; end
        S_PWAIT: if (tmr >= TW'(POWER_WAIT - 1)) st <= S_BURST;
        default: if (cmd_ack && pend) begin
          case (st)
            S_BURST: st <= S_RST;
            S_RST:   st <= r1_idle ? S_PROBE : S_FAIL;
            S_PROBE: begin
              tmr <= '0;
              if (r1_illeg) begin
                v2 <= 1'b0;
                st <= S_APP;
              end else if (r1_idle && cmd_ext[11:0] == 12'h1AA) begin
                v2 <= 1'b1;
                st <= S_APP;
              end else st <= S_FAIL;
            end
            S_APP: begin
              if (r1_illeg && !v2)                     st <= S_MMCOP;
              else if (cmd_nores || cmd_r1[7:1] != 7'd0) st <= S_FAIL;
              else                                     st <= S_SDOP;
            end
            S_SDOP: begin
              if (r1_ok) begin
                if (v2) st <= S_OCR;
                else begin typ <= 2'd1; st <= S_BLEN; end
              end else if (r1_idle)      st <= tmo ? S_FAIL : S_APP;
              else if (r1_illeg && !v2)  st <= S_MMCOP;
              else                       st <= S_FAIL;
            end
            S_MMCOP: begin
              if (r1_ok) begin typ <= 2'd0; st <= S_BLEN; end
              else if (r1_idle) st <= tmo ? S_FAIL : S_MMCOP;
              else              st <= S_FAIL;
            end
            S_OCR: begin
              if (r1_ok) begin
                typ <= cmd_ext[30] ? 2'd3 : 2'd2;
                st  <= cmd_ext[30] ? S_DONE : S_BLEN;
              end else st <= S_FAIL;
            end
            S_BLEN:  st <= r1_ok ? S_DONE : S_FAIL;
            default: st <= S_FAIL;
          endcase
        end
      endcase
    end
  end
endmodule

module sdcard_init_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        fast_clk,
  input logic        cmd_req,
  input logic        idle_burst,
  input logic [5:0]  cmd_idx,
  input logic [31:0] cmd_arg,
  input logic [7:0]  cmd_crc,
  input logic        cmd_r32,
  input logic [1:0]  card_type,
  input logic        ready,
  input logic        error
);
  p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |=> !cmd_req);
  p_burst_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && idle_burst) |-> cs_n);
  p_reset_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !idle_burst && cmd_idx == 6'd0) |-> (cmd_crc == 8'h95 && !cs_n && cmd_arg == 32'd0));
  p_probe_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_idx == 6'd8) |-> (cmd_arg == 32'h1AA && cmd_crc == 8'h87 && cmd_r32));
  p_blen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_idx == 6'd16) |-> (cmd_arg == 32'd512 && card_type != 2'd3));
  p_ready_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> (ready && !error && fast_clk));
  p_error_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> (error && !ready && !fast_clk));
  p_end_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready || error) |-> (cs_n && !cmd_req));
endmodule

bind sdcard_init_seq sdcard_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fast_clk(fast_clk), .cmd_req(cmd_req),
  .idle_burst(idle_burst), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .cmd_crc(cmd_crc),
  .cmd_r32(cmd_r32), .card_type(card_type), .ready(ready), .error(error)
);

// File: tb/test_sdcard_init_seq.sv
module test_sdcard_init_seq;
  localparam int PW = 100;
  localparam int TO = 3000;

  logic clk = 0, rst_n = 0, start = 0, cmd_ack = 0, cmd_nores = 0;
  logic [7:0] cmd_r1 = 0;
  logic [31:0] cmd_ext = 0;
  logic cs_n, fast_clk, cmd_req, idle_burst, cmd_r32, ready, error;
  logic [5:0] cmd_idx;
  logic [31:0] cmd_arg;
  logic [7:0] cmd_crc;
  logic [1:0] card_type;

  sdcard_init_seq #(.POWER_WAIT(PW), .INIT_TIMEOUT(TO)) i_sdcard_init_seq (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // card model configuration and observation log
  int kind = 0, busy = 0, bad0 = 0; bit badpat = 0;
  int polls, n41, n1, n16, nreq, first_req;
  bit burst_ok, c0_ok, c8_ok, hcs_bad;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    @(negedge clk);
    forever begin
      while (!cmd_req) @(negedge clk);
      begin
        logic [5:0] idx; logic [31:0] arg; logic [7:0] crc; logic r32, ib, cs;
        idx = cmd_idx; arg = cmd_arg; crc = cmd_crc; r32 = cmd_r32; ib = idle_burst; cs = cs_n;
        nreq++;
        if (first_req < 0) first_req = cyc;
        cmd_nores = 0; cmd_r1 = 8'hFF; cmd_ext = 0;
        if (ib) burst_ok = cs;
        else case (idx)
          6'd0: begin
            c0_ok = (crc == 8'h95) && !cs && arg == 0;
            if (bad0 == 2) cmd_nores = 1; else cmd_r1 = (bad0 == 1) ? 8'h00 : 8'h01;
          end
          6'd8: begin
            c8_ok = (arg == 32'h1AA) && (crc == 8'h87) && r32;
            if (kind >= 2) begin cmd_r1 = 8'h01; cmd_ext = badpat ? 32'h1A5 : {20'd0, arg[11:0]}; end
            else cmd_r1 = 8'h05;
          end
          6'd55: cmd_r1 = (kind == 0) ? 8'h05 : 8'h01;
          6'd41: begin
            n41++;
            if (arg[30] != (kind >= 2)) hcs_bad = 1;
            if (kind == 0) cmd_r1 = 8'h05;
            else begin cmd_r1 = (polls < busy) ? 8'h01 : 8'h00; polls++; end
          end
          6'd1: begin n1++; cmd_r1 = (polls < busy) ? 8'h01 : 8'h00; polls++; end
          6'd58: begin cmd_r1 = 8'h00; cmd_ext = (kind == 3) ? 32'hC0FF_8000 : 32'h80FF_8000; end
          6'd16: begin n16++; cmd_r1 = (arg == 512) ? 8'h00 : 8'h04; end
          default: cmd_r1 = 8'h04;
        endcase
        repeat ($urandom_range(1, 6)) @(negedge clk);
        cmd_ack = 1;
        @(negedge clk);
        cmd_ack = 0;
      end
    end
  end

  function automatic bit exp_err(int k, int b, int z, bit p);
    return (z != 0) || (p && k >= 2) || (b > 100);
  endfunction

  task automatic run_case(input int k, input int b, input bit p, input int z);
    bit ee; int t0, n; bit done;
    kind = k; busy = b; badpat = p; bad0 = z;
    polls = 0; n41 = 0; n1 = 0; n16 = 0; nreq = 0; first_req = -1;
    burst_ok = 0; c0_ok = 0; c8_ok = 0; hcs_bad = 0;
    ee = exp_err(k, b, z, p);
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    chk(cs_n && !fast_clk && !ready && !error && !cmd_req, "R1 reset state", {cs_n, fast_clk, ready, error, cmd_req}, 5'b10000);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n && !fast_clk && !ready && !error && !cmd_req, "R1 after reset", {cs_n, fast_clk, ready, error, cmd_req}, 5'b10000);
    start = 1; t0 = cyc; @(negedge clk); start = 0;
    done = 0;
    for (int i = 0; i < 40000 && !done; i++) begin
      @(negedge clk);
      done = ready || error;
    end
    chk(done, "R9 sequence ends", done, 1);
    chk(burst_ok && (first_req - t0) >= PW, "R2 wait and idle burst", first_req - t0, PW);
    chk(c0_ok, "R3 reset command fields", c0_ok, 1);
    chk(error == ee && ready == !ee, "R3/R4/R9 outcome error", error, ee);
    if (z == 0) chk(c8_ok, "R4 probe fields", c8_ok, 1);
    if (!ee) begin
      chk(card_type == 2'(k), "R6/R7 card type", card_type, k);
      chk(n16 == ((k != 3) ? 1 : 0), "R8 block length count", n16, (k != 3) ? 1 : 0);
      if (k == 0) chk(n1 == b + 1, "R6 index-1 polls", n1, b + 1);
      else begin
        chk(n41 == b + 1, "R5 index-41 polls", n41, b + 1);
        chk(!hcs_bad, "R5 capacity bit", hcs_bad, 0);
      end
      chk(fast_clk && cs_n, "R10 fast clock at ready", {fast_clk, cs_n}, 2'b11);
    end else chk(!fast_clk && cs_n, "R10 slow clock on error", {fast_clk, cs_n}, 2'b01);
    n = nreq;
    start = 1; @(negedge clk); start = 0;
    repeat (PW + 20) @(negedge clk);
    chk(nreq == n && ready == !ee && error == ee, "R10 start ignored at end", nreq, n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 4; k++) run_case(k, 3, 0, 0);
    for (int k = 0; k < 4; k++) run_case(k, 0, 0, 0);
    run_case(2, 2, 1, 0);
    run_case(3, 0, 0, 1);
    run_case(1, 0, 0, 2);
    run_case(2, 100000, 0, 0);
    run_case(0, 100000, 0, 0);
    for (int i = 0; i < 10; i++) run_case($urandom_range(0, 3), $urandom_range(0, 15), 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule